// File: doc/BRIEF.md
# Key-Protected Configuration Register File

This block holds a set of 32-bit configuration words behind a small word-addressed register bus. It starts out locked. While it is locked, a bus master cannot change the ordinary configuration words. To open the block, the master writes a 16-bit key to a dedicated unlock word. To close it again, the master writes a different key to a dedicated lock word. One control word with a single stored bit stays writable at all times.

Every word index is classified as read-write, read-only, write-only or unmapped. An access that does not fit its class produces a one-cycle error pulse. A refused write leaves the stored state untouched. The block also contains a reset-control word. An accepted write to that word with bit 0 set produces a one-cycle system-reset request. A handful of words come out of reset with fixed nonzero values: three PLL-style control words, a status word and an identification word. Real clock or pin behaviour is not modelled.

Top module: `keyreg_file`

## Requirements
- R1: After reset the block is locked and `rd_data`, `acc_err` and `sys_rst_req` are 0. The reset values are as follows. Word 3 reads 1. Words 0x40..0x42 read 0x0001A008. Word 0x43 reads 0x0000003F. Word 0x14C reads `ID_CODE` (default 0x1A5C0001). Every other word reads 0.
- R2: Word 1 is write-only. A write to it whose data bits [15:0] equal 0x767B sets the lock flag. Any other value leaves the flag unchanged. This write never raises an error.
- R3: Word 2 is write-only. A write to it whose data bits [15:0] equal 0xDF0D clears the lock flag, whatever the upper bits hold. Any other value leaves the flag unchanged. This write never raises an error.
- R4: Word 3 is read-only. Its bit 0 equals the lock flag and all its other bits read 0.
- R5: While the block is locked, a write to a read-write word (0x40..0x42, 0x48..0x4F, 0x80) is discarded. `acc_err` is then high for exactly the next cycle.
- R6: Word 0 accepts writes whether the block is locked or not. It stores only data bit 0, and bits [31:1] read 0.
- R7: A write to a read-only word (3, 0x43, 0x14C) or to an unmapped word is discarded. `acc_err` is then high for the next cycle.
- R8: A read of a write-only word (1, 2) or of an unmapped word raises `acc_err` for the next cycle and returns 0.
- R9: An accepted write (block unlocked) to word 0x80 is stored. If data bit 0 is 1, `sys_rst_req` is high for exactly the next cycle. Otherwise `sys_rst_req` stays low.
- R10: Read data appears on `rd_data` in the cycle after `rd_en` and holds while `rd_en` is low. A read and a write to the same word in one cycle return the old value.
- R11: While the block is unlocked, the words 0x40..0x42, 0x48..0x4F and 0x80 store the full 32-bit write data and read it back. Word 0x43 always reads 0x3F, and word 0x14C always reads `ID_CODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| rd_en | input | 1 | Read strobe for the word at `addr` |
| addr | input | AW | Word index (byte offset divided by 4) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle pulse after an illegal access |
| sys_rst_req | output | 1 | One-cycle system-reset request |

## Verification
The assertions assume that `rst_n` is released away from a clock edge. They also assume that each strobe is sampled together with a stable `addr` and `wr_data` for the whole cycle. Both strobes may be high in the same cycle, and nothing else is assumed about how the strobes are combined. To stay within these assumptions, the stimulus changes every input only at the falling clock edge and samples outputs at the following falling edge. It sweeps every one of the 1024 word indices, once while the block is locked and once while it is unlocked. Write data in the sweeps is built so that no key value lands by accident, and the keys are only ever written on purpose.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;

  localparam int unsigned DW = 32;

  localparam logic [15:0] KEY_CLOSE = 16'h767B;
  localparam logic [15:0] KEY_OPEN  = 16'hDF0D;

  // word indices whose position carries behaviour
  localparam int W_CTRL   = 0;
  localparam int W_LOCK   = 1;
  localparam int W_UNLOCK = 2;
  localparam int W_STATUS = 3;

  typedef enum logic [2:0] {
    K_UNMAPPED,
    K_RW,
    K_RO,
    K_WO,
    K_OPEN
  } kind_e;

  typedef enum logic [3:0] {
    T_NONE,
    T_CTRL,
    T_LOCK,
    T_UNLOCK,
    T_STATUS,
    T_PLL,
    T_PLLSTS,
    T_BANK,
    T_RST,
    T_ID
  } tgt_e;

endpackage

// File: rtl/keyreg_decode.sv
module keyreg_decode
  import keyreg_pkg::*;
#(
  parameter int AW        = 10,
  parameter int PLL_BASE  = 'h40,
  parameter int NUM_PLL   = 3,
  parameter int BANK_BASE = 'h48,
  parameter int NUM_BANK  = 8,
  parameter int RST_WORD  = 'h80,
  parameter int ID_WORD   = 'h14C,
  parameter int IDX_W     = 3
) (
  input  logic [AW-1:0]    addr,
  output tgt_e             tgt,
  output kind_e            kind,
  output logic [IDX_W-1:0] idx
);

  localparam int PLLSTS_WORD = PLL_BASE + NUM_PLL;

  int a;

  always_comb begin
    a   = int'(addr);
    tgt = T_NONE;
    idx = '0;
    if (a == W_CTRL) begin
      tgt = T_CTRL;
    end else if (a == W_LOCK) begin
      tgt = T_LOCK;
    end else if (a == W_UNLOCK) begin
      tgt = T_UNLOCK;
    end else if (a == W_STATUS) begin
      tgt = T_STATUS;
    end else if (a >= PLL_BASE && a < PLL_BASE + NUM_PLL) begin
      tgt = T_PLL;
      idx = IDX_W'(a - PLL_BASE);
    end else if (a == PLLSTS_WORD) begin
      tgt = T_PLLSTS;
    end else if (a >= BANK_BASE && a < BANK_BASE + NUM_BANK) begin
      tgt = T_BANK;
      idx = IDX_W'(a - BANK_BASE);
    end else if (a == RST_WORD) begin
      tgt = T_RST;
    end else if (a == ID_WORD) begin
      tgt = T_ID;
    end
  end

  always_comb begin
    unique case (tgt)
      T_CTRL:                     kind = K_OPEN;
      T_LOCK, T_UNLOCK:           kind = K_WO;
      T_STATUS, T_PLLSTS, T_ID:   kind = K_RO;
      T_PLL, T_BANK, T_RST:       kind = K_RW;
      default:                    kind = K_UNMAPPED;
    endcase
  end

endmodule

// File: rtl/keyreg_lock.sv
module keyreg_lock
  import keyreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  tgt_e        tgt,
  input  logic [15:0] key,
  output logic        lock_q
);

  logic lock_d;

  always_comb begin
    lock_d = lock_q;
    if (wr_en && tgt == T_LOCK && key == KEY_CLOSE) begin
      lock_d = 1'b1;
    end else if (wr_en && tgt == T_UNLOCK && key == KEY_OPEN) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
    end else begin
      lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/keyreg_store.sv
module keyreg_store
  import keyreg_pkg::*;
#(
  parameter int          NUM_PLL    = 3,
  parameter int          NUM_BANK   = 8,
  parameter int          IDX_W      = 3,
  parameter logic [31:0] PLL_RESET  = 32'h0001_A008,
  parameter logic [31:0] BANK_RESET = 32'h0000_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_ok,
  input  tgt_e                          tgt,
  input  logic [IDX_W-1:0]              idx,
  input  logic [DW-1:0]                 wr_data,
  output logic                          ctrl_q,
  output logic [NUM_PLL-1:0][DW-1:0]    pll_q,
  output logic [NUM_BANK-1:0][DW-1:0]   bank_q,
  output logic [DW-1:0]                 rstw_q
);

  logic          ctrl_en;
  logic          ctrl_d;
  logic          rstw_en;
  logic [DW-1:0] rstw_d;

  always_comb begin
    ctrl_en = wr_ok && tgt == T_CTRL;
    ctrl_d  = ctrl_en ? wr_data[0] : ctrl_q;
    rstw_en = wr_ok && tgt == T_RST;
    rstw_d  = rstw_en ? wr_data : rstw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      rstw_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rstw_q <= rstw_d;
    end
  end

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    logic          en;
    logic [DW-1:0] d;
    always_comb begin
      en = wr_ok && tgt == T_PLL && idx == IDX_W'(g);
      d  = en ? wr_data : pll_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pll_q[g] <= PLL_RESET;
      else        pll_q[g] <= d;
    end
  end

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
    logic          en;
    logic [DW-1:0] d;
    always_comb begin
      en = wr_ok && tgt == T_BANK && idx == IDX_W'(g);
      d  = en ? wr_data : bank_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[g] <= BANK_RESET;
      else        bank_q[g] <= d;
    end
  end

endmodule

// File: rtl/keyreg_file.sv
module keyreg_file
  import keyreg_pkg::*;
#(
  parameter int          AW         = 10,
  parameter int          PLL_BASE   = 'h40,
  parameter int          NUM_PLL    = 3,
  parameter int          BANK_BASE  = 'h48,
  parameter int          NUM_BANK   = 8,
  parameter int          RST_WORD   = 'h80,
  parameter int          ID_WORD    = 'h14C,
  parameter logic [31:0] PLL_RESET  = 32'h0001_A008,
  parameter logic [31:0] PLL_STATUS = 32'h0000_003F,
  parameter logic [31:0] ID_CODE    = 32'h1A5C_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  output logic          acc_err,
  output logic          sys_rst_req
);

  localparam int MAX_IDX = (NUM_BANK > NUM_PLL) ? NUM_BANK : NUM_PLL;
  localparam int IDX_W   = (MAX_IDX > 2) ? $clog2(MAX_IDX) : 1;

  tgt_e                        tgt;
  kind_e                       kind;
  logic [IDX_W-1:0]            idx;
  logic                        lock_flag;
  logic                        ctrl_q;
  logic [NUM_PLL-1:0][DW-1:0]  pll_q;
  logic [NUM_BANK-1:0][DW-1:0] bank_q;
  logic [DW-1:0]               rstw_q;

  logic          wr_ok;
  logic          err_d;
  logic          req_d;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rd_d;

  keyreg_decode #(
    .AW(AW), .PLL_BASE(PLL_BASE), .NUM_PLL(NUM_PLL), .BANK_BASE(BANK_BASE),
    .NUM_BANK(NUM_BANK), .RST_WORD(RST_WORD), .ID_WORD(ID_WORD), .IDX_W(IDX_W)
  ) u_decode (
    .addr(addr),
    .tgt (tgt),
    .kind(kind),
    .idx (idx)
  );

  keyreg_lock u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .tgt   (tgt),
    .key   (wr_data[15:0]),
    .lock_q(lock_flag)
  );

  keyreg_store #(
    .NUM_PLL(NUM_PLL), .NUM_BANK(NUM_BANK), .IDX_W(IDX_W),
    .PLL_RESET(PLL_RESET), .BANK_RESET(32'h0)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ok  (wr_ok),
    .tgt    (tgt),
    .idx    (idx),
    .wr_data(wr_data),
    .ctrl_q (ctrl_q),
    .pll_q  (pll_q),
    .bank_q (bank_q),
    .rstw_q (rstw_q)
  );

  // write acceptance and access errors
  always_comb begin
    wr_ok = wr_en && ((kind == K_RW && !lock_flag) || kind == K_OPEN);
    err_d = (wr_en && (kind == K_RO || kind == K_UNMAPPED ||
                       (kind == K_RW && lock_flag)))
         || (rd_en && (kind == K_WO || kind == K_UNMAPPED));
    req_d = wr_ok && tgt == T_RST && wr_data[0];
  end

  // read selection from current (pre-write) state
  always_comb begin
    rd_mux = '0;
    unique case (tgt)
      T_CTRL:   rd_mux = {31'b0, ctrl_q};
      T_STATUS: rd_mux = {31'b0, lock_flag};
      T_PLL: begin
        for (int i = 0; i < NUM_PLL; i++) begin
          if (idx == IDX_W'(i)) rd_mux = pll_q[i];
        end
      end
      T_PLLSTS: rd_mux = PLL_STATUS;
      T_BANK: begin
        for (int i = 0; i < NUM_BANK; i++) begin
          if (idx == IDX_W'(i)) rd_mux = bank_q[i];
        end
      end
      T_RST:    rd_mux = rstw_q;
      T_ID:     rd_mux = ID_CODE;
      default:  rd_mux = '0;
    endcase
    rd_d = rd_en ? rd_mux : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      acc_err     <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      rd_data     <= rd_d;
      acc_err     <= err_d;
      sys_rst_req <= req_d;
    end
  end

endmodule

// File: rtl/keyreg_file_chk.sv
module keyreg_file_chk
  import keyreg_pkg::*;
#(
  parameter int AW       = 10,
  parameter int PLL_BASE = 'h40,
  parameter int RST_WORD = 'h80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   wr_data,
  input logic [31:0]   rd_data,
  input logic          acc_err,
  input logic          sys_rst_req,
  input logic          lock_flag,
  input logic [31:0]   pll0
);

  a_r2_lock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(W_LOCK) && wr_data[15:0] == KEY_CLOSE) |=> lock_flag);

  a_r3_unlock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(W_UNLOCK) && wr_data[15:0] == KEY_OPEN) |=> !lock_flag);

  a_r2_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lock_flag));

  a_r4_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(W_STATUS)) |=> acc_err);

  a_r5_locked_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_flag && wr_en && addr == AW'(PLL_BASE)) |=> ($stable(pll0) && acc_err));

  a_r9_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(wr_en && !lock_flag && addr == AW'(RST_WORD) && wr_data[0]));

  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind keyreg_file keyreg_file_chk #(
  .AW(AW), .PLL_BASE(PLL_BASE), .RST_WORD(RST_WORD)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .acc_err    (acc_err),
  .sys_rst_req(sys_rst_req),
  .lock_flag  (lock_flag),
  .pll0       (pll_q[0])
);

// File: tb/keyreg_file_bench.sv
module keyreg_file_bench;

  localparam int          NW      = 1024;
  localparam logic [31:0] ID_EXP  = 32'h1A5C_0001;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [9:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        acc_err;
  logic        sys_rst_req;

  int checks;
  int errors;
  bit done;

  logic [31:0] model [NW];
  bit          lk;

  keyreg_file u_keyreg_file (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .acc_err(acc_err),
    .sys_rst_req(sys_rst_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // 0 unmapped, 1 read-write, 2 read-only, 3 write-only, 4 always writable
  function automatic int cls(int a);
    if (a == 0) return 4;
    if (a == 1 || a == 2) return 3;
    if (a == 3 || a == 'h43 || a == 'h14C) return 2;
    if ((a >= 'h40 && a < 'h43) || (a >= 'h48 && a < 'h50) || a == 'h80) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] reset_val(int a);
    if (a == 3) return 32'h1;
    if (a >= 'h40 && a < 'h43) return 32'h0001_A008;
    if (a == 'h43) return 32'h0000_003F;
    if (a == 'h14C) return ID_EXP;
    return 32'h0;
  endfunction

  function automatic string tag_of(int a);
    case (cls(a))
      1: return "R11";
      2: return "R7";
      3: return "R8";
      4: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(bit do_rd, bit do_wr, int a, logic [31:0] d, string req);
    int          c;
    bit          e_err;
    bit          e_req;
    logic [31:0] e_rd;
    c     = cls(a);
    e_err = (do_wr && (c == 2 || c == 0 || (c == 1 && lk)))
         || (do_rd && (c == 3 || c == 0));
    e_req = do_wr && c == 1 && !lk && a == 'h80 && d[0];
    e_rd  = (c == 3 || c == 0) ? 32'h0 : model[a];
    if (do_wr) begin
      if (a == 1 && d[15:0] == 16'h767B) lk = 1'b1;
      if (a == 2 && d[15:0] == 16'hDF0D) lk = 1'b0;
      if (c == 4) model[0] = {31'b0, d[0]};
      if (c == 1 && !(lk && !(a == 1 || a == 2)) && !e_err) model[a] = d;
      model[3] = {31'b0, lk};
    end
    wr_en   = do_wr;
    rd_en   = do_rd;
    addr    = 10'(a);
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    chk(req, "acc_err", {31'b0, acc_err}, {31'b0, e_err});
    chk(e_req ? "R9" : req, "sys_rst_req", {31'b0, sys_rst_req}, {31'b0, e_req});
    if (do_rd) chk(req, "rd_data", rd_data, e_rd);
  endtask

  task automatic read_sweep(string req);
    for (int a = 0; a < NW; a++) begin
      op(1'b1, 1'b0, a, 32'h0, (req == "") ? tag_of(a) : req);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    rd_en   = 1'b0;
    addr    = '0;
    wr_data = '0;
    lk      = 1'b1;
    for (int a = 0; a < NW; a++) model[a] = reset_val(a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    chk("R1", "rd_data", rd_data, 32'h0);
    chk("R1", "acc_err", {31'b0, acc_err}, 32'h0);
    chk("R1", "sys_rst_req", {31'b0, sys_rst_req}, 32'h0);
    read_sweep("R1");

    // R5 R7 R6: locked write sweep, then read back
    for (int a = 0; a < NW; a++) begin
      op(1'b0, 1'b1, a, 32'h5A00_0000 ^ (32'(a) * 32'h0001_0101),
         (cls(a) == 1) ? "R5" : tag_of(a));
    end
    read_sweep("R5");

    // R3 wrong key then right key with garbage upper half; R4 status
    op(1'b0, 1'b1, 2, 32'h0000_DF0C, "R3");
    op(1'b1, 1'b0, 3, 32'h0, "R3");
    chk("R4", "locked status", rd_data, 32'h1);
    op(1'b0, 1'b1, 2, 32'hFFFF_DF0D, "R3");
    op(1'b1, 1'b0, 3, 32'h0, "R4");
    chk("R4", "unlocked status", rd_data, 32'h0);

    // R11 R9 R7: unlocked write sweep, then read back
    for (int a = 0; a < NW; a++) begin
      op(1'b0, 1'b1, a, {16'hC3A5, 5'b0, 10'(a), 1'b1}, tag_of(a));
    end
    read_sweep("");

    // R9 bit 0 clear: stored, no request; back-to-back requests
    op(1'b0, 1'b1, 'h80, 32'h1234_5670, "R9");
    op(1'b1, 1'b0, 'h80, 32'h0, "R9");
    op(1'b0, 1'b1, 'h80, 32'h0000_0001, "R9");
    op(1'b0, 1'b1, 'h80, 32'h0000_0003, "R9");
    op(1'b0, 1'b1, 'h81, 32'h0000_0001, "R9");

    // R10 same-cycle read and write returns the old value
    op(1'b0, 1'b1, 'h4A, 32'hAAAA_0001, "R10");
    op(1'b1, 1'b1, 'h4A, 32'hBBBB_0002, "R10");
    chk("R10", "old value", rd_data, 32'hAAAA_0001);
    hold = rd_data;
    op(1'b0, 1'b0, 0, 32'h0, "R10");
    chk("R10", "hold", rd_data, hold);
    op(1'b1, 1'b0, 'h4A, 32'h0, "R10");
    chk("R10", "new value", rd_data, 32'hBBBB_0002);

    // R2 wrong key then right key; locked bank write refused; R6 open word
    op(1'b0, 1'b1, 1, 32'h0000_767A, "R2");
    op(1'b1, 1'b0, 3, 32'h0, "R2");
    chk("R2", "still unlocked", rd_data, 32'h0);
    op(1'b0, 1'b1, 1, 32'h9999_767B, "R2");
    op(1'b1, 1'b0, 3, 32'h0, "R2");
    chk("R2", "locked again", rd_data, 32'h1);
    op(1'b0, 1'b1, 'h4A, 32'hDEAD_BEEF, "R5");
    op(1'b1, 1'b0, 'h4A, 32'h0, "R5");
    op(1'b0, 1'b1, 0, 32'hFFFF_FFFE, "R6");
    op(1'b1, 1'b0, 0, 32'h0, "R6");
    op(1'b0, 1'b1, 0, 32'hFFFF_FFFF, "R6");
    op(1'b1, 1'b0, 0, 32'h0, "R6");
    op(1'b0, 1'b1, 'h80, 32'h0000_0001, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule